// File: doc/BRIEF.md
# Three-Word Fetch Microsequencer

This block is the control unit of a small three-bus, 16-bit datapath. It does not move data itself. In every cycle it produces one control word. That word names the source feeding each ALU input, the ALU function, the set of registers that load at the next edge, the memory read and write strobes, the program-counter increment and the program-counter clear. Each result is carried on the ALU output bus into whichever registers are enabled.

Every instruction is fetched as three consecutive memory words: the opcode word, an address word and an operand word. All three are fetched even when the instruction uses fewer. The sequencer then dispatches on the opcode word, which the datapath presents on `ir0`, and steps through the microsteps for that instruction. The supported operations are:

- register add
- memory-operand add
- indexed add
- literal add
- indexed literal store
- branch if zero
- subroutine call
- subroutine return

Unsupported encodings fall straight back to fetch. The third instruction word doubles as scratch space: the indexed add writes its computed address back into it.

Top module: `triword_useq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer is placed at the first fetch step. During any cycle in which `rst` is high, `pc_clr` is 1 and every other output is 0. The first cycle after reset is a fetch address step.
- R2: Each instruction word is fetched in three steps, repeated for IR0, then IR1, then IR2:
  - Address step: `src_a`=PC(5), `alu_fn`=pass(1), load MAR, `pc_inc`=1.
  - Read step: `mem_rd`=1, load MBR_read.
  - Load step: `src_a`=MBR_read(7), pass, load IRn.
  With memory ready, a fetch takes 9 cycles. Source codes are 0 none, 1 R0, 2 R1, 3 IR1, 4 IR2, 5 PC, 6 Ret, 7 MBR_read. ALU codes are 0 idle, 1 pass A, 2 add. Load-enable bits are 0 MAR, 1 MBR_read, 2 MBR_write, 3 IR0, 4 IR1, 5 IR2, 6 R0, 7 PC, 8 Ret.
- R3: While a read or write step sees `mem_ready` low, the step repeats with its strobe held and all load enables 0. MBR_read loads only in a read cycle with `mem_ready` high. `mem_rd` and `mem_wr` are never both 1.
- R4: Class 0 (IR0[12:10]) with parameter 0 (IR0[5:2]) is a register add. It takes one step: A=R0, B=R1, add, load R0.
- R5: Class 0 with parameter 1 is a memory-operand add:
  - IR1 is passed into MAR.
  - A read step follows.
  - Then A=R0, B=MBR_read, add, load R0.
- R6: Class 0 with parameter 2 is an indexed add. It first computes A=R1, B=IR2, add, and loads IR2. It then continues as R5 with IR2 in place of IR1.
- R7: Class 0 with parameter 3 is a literal add. It takes one step: A=R0, B=IR1, add, load R0.
- R8: Class 1, with any parameter, is an indexed literal store:
  - A=R0, B=IR2, add, load MAR.
  - IR1 is passed into MBR_write.
  - A write step with `mem_wr`=1 follows.
- R9: Class 5 with parameter 0 is a branch if zero. It takes one step: A=PC, B=IR1, add. PC loads only when `z_flag` is 1.
- R10: Class 5 with parameter 1 is a call. PC is first passed into Ret. Then A=PC, B=IR1, add, load PC.
- R11: Class 5 with parameter 2 is a return. Ret is passed into PC.
- R12: Every other class or parameter combination executes no step: the next cycle is a fetch address step. The predicate, register and constant fields of IR0 never change the sequence. After the last step of any instruction, fetch restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir0 | input | IR_W | Opcode word held in IR0 by the datapath |
| z_flag | input | 1 | Zero condition flag |
| mem_ready | input | 1 | Memory completes the current read or write |
| src_a | output | 3 | Source selected onto ALU input A |
| src_b | output | 3 | Source selected onto ALU input B |
| alu_fn | output | 2 | ALU function: idle, pass A, add |
| ld_en | output | 9 | Register load enables for the next edge |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_inc | output | 1 | Increment PC at the next edge |
| pc_clr | output | 1 | Clear PC at the next edge |

## Verification
Two pairs of functions can coincide in one cycle, and each pair is provoked on purpose.

The first pair is the memory handshake and the register load. In the cycle where `mem_ready` rises during a read, the sequencer must both load MBR_read and advance. The bench holds ready low for several cycles in a fetch read, in an operand read and in a store write. It expects the held step with no loads in each stalled cycle, then the loading step exactly once.

The second pair is reset and execution. The bench raises `rst` in the middle of a call. It judges that the clear word replaces the execute step, and that a fetch address step follows rather than the rest of the call.

// File: rtl/ms_pkg.sv
package ms_pkg;

  localparam int SRC_W = 3;
  localparam int FN_W  = 2;
  localparam int LD_W  = 9;

  localparam logic [SRC_W-1:0] SRC_NONE = 3'd0;
  localparam logic [SRC_W-1:0] SRC_R0   = 3'd1;
  localparam logic [SRC_W-1:0] SRC_R1   = 3'd2;
  localparam logic [SRC_W-1:0] SRC_IR1  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_IR2  = 3'd4;
  localparam logic [SRC_W-1:0] SRC_PC   = 3'd5;
  localparam logic [SRC_W-1:0] SRC_RET  = 3'd6;
  localparam logic [SRC_W-1:0] SRC_MBRR = 3'd7;

  localparam logic [FN_W-1:0] FN_IDLE = 2'd0;
  localparam logic [FN_W-1:0] FN_PASS = 2'd1;
  localparam logic [FN_W-1:0] FN_ADD  = 2'd2;

  localparam int LD_MAR  = 0;
  localparam int LD_MBRR = 1;
  localparam int LD_MBRW = 2;
  localparam int LD_IR0  = 3;
  localparam int LD_IR1  = 4;
  localparam int LD_IR2  = 5;
  localparam int LD_R0   = 6;
  localparam int LD_PC   = 7;
  localparam int LD_RET  = 8;

  typedef enum logic [4:0] {
    S_FA0, S_FR0, S_FL0,
    S_FA1, S_FR1, S_FL1,
    S_FA2, S_FR2, S_FL2,
    S_RADD,
    S_MA, S_IMA, S_MRD, S_MACC,
    S_IDX,
    S_LIT,
    S_SA, S_SD, S_SWR,
    S_BEQ,
    S_CS, S_CJ,
    S_RET
  } ustep_t;

  typedef struct packed {
    logic [SRC_W-1:0] sa;
    logic [SRC_W-1:0] sb;
    logic [FN_W-1:0]  fn;
    logic [LD_W-1:0]  ld;
    logic             rd;
    logic             wr;
    logic             inc;
  } uword_t;

  function automatic logic [LD_W-1:0] ld_bit(input int idx);
    return LD_W'(1) << idx;
  endfunction

  function automatic uword_t mk(input logic [SRC_W-1:0] a, input logic [SRC_W-1:0] b,
                                input logic [FN_W-1:0] f, input logic [LD_W-1:0] l,
                                input logic r, input logic w, input logic i);
    uword_t u;
    u.sa = a; u.sb = b; u.fn = f; u.ld = l;
    u.rd = r; u.wr = w; u.inc = i;
    return u;
  endfunction

endpackage

// File: rtl/ms_decode.sv
module ms_decode import ms_pkg::*; #(
  parameter int IR_W = 16
) (
  input  logic [IR_W-1:0] ir0,
  output ustep_t          first
);
  localparam int CLS_W  = 3;
  localparam int PRM_W  = 4;
  localparam int PRM_LO = 2;
  localparam int CLS_LO = PRM_LO + PRM_W + 4;

  localparam logic [CLS_W-1:0] C_ARITH = 3'd0;
  localparam logic [CLS_W-1:0] C_STORE = 3'd1;
  localparam logic [CLS_W-1:0] C_FLOW  = 3'd5;

  logic [CLS_W-1:0] cls;
  logic [PRM_W-1:0] prm;

  assign cls = ir0[CLS_LO +: CLS_W];
  assign prm = ir0[PRM_LO +: PRM_W];

  always_comb begin
    first = S_FA0;
    unique case (cls)
      C_ARITH: begin
        case (prm)
          4'd0:    first = S_RADD;
          4'd1:    first = S_MA;
          4'd2:    first = S_IDX;
          4'd3:    first = S_LIT;
          default: first = S_FA0;
        endcase
      end
      C_STORE: first = S_SA;
      C_FLOW: begin
        case (prm)
          4'd0:    first = S_BEQ;
          4'd1:    first = S_CS;
          4'd2:    first = S_RET;
          default: first = S_FA0;
        endcase
      end
      default: first = S_FA0;
    endcase
  end
endmodule

// File: rtl/ms_ustore.sv
module ms_ustore import ms_pkg::*; (
  input  ustep_t st,
  input  logic   z_flag,
  input  logic   mem_ready,
  output uword_t uw,
  output ustep_t nxt,
  output logic   dispatch
);
  logic [LD_W-1:0] rd_ld;
  assign rd_ld = mem_ready ? ld_bit(LD_MBRR) : '0;

  always_comb begin
    uw       = mk(SRC_NONE, SRC_NONE, FN_IDLE, '0, 1'b0, 1'b0, 1'b0);
    nxt      = S_FA0;
    dispatch = 1'b0;
    case (st)
      S_FA0: begin uw = mk(SRC_PC, SRC_NONE, FN_PASS, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b1); nxt = S_FR0; end
      S_FR0: begin uw = mk(SRC_NONE, SRC_NONE, FN_IDLE, rd_ld, 1'b1, 1'b0, 1'b0); nxt = S_FL0; end
      S_FL0: begin uw = mk(SRC_MBRR, SRC_NONE, FN_PASS, ld_bit(LD_IR0), 1'b0, 1'b0, 1'b0); nxt = S_FA1; end
      S_FA1: begin uw = mk(SRC_PC, SRC_NONE, FN_PASS, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b1); nxt = S_FR1; end
      S_FR1: begin uw = mk(SRC_NONE, SRC_NONE, FN_IDLE, rd_ld, 1'b1, 1'b0, 1'b0); nxt = S_FL1; end
      S_FL1: begin uw = mk(SRC_MBRR, SRC_NONE, FN_PASS, ld_bit(LD_IR1), 1'b0, 1'b0, 1'b0); nxt = S_FA2; end
      S_FA2: begin uw = mk(SRC_PC, SRC_NONE, FN_PASS, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b1); nxt = S_FR2; end
      S_FR2: begin uw = mk(SRC_NONE, SRC_NONE, FN_IDLE, rd_ld, 1'b1, 1'b0, 1'b0); nxt = S_FL2; end
      S_FL2: begin
        uw = mk(SRC_MBRR, SRC_NONE, FN_PASS, ld_bit(LD_IR2), 1'b0, 1'b0, 1'b0);
        dispatch = 1'b1;
      end
      S_RADD: uw = mk(SRC_R0, SRC_R1, FN_ADD, ld_bit(LD_R0), 1'b0, 1'b0, 1'b0);
      S_MA:   begin uw = mk(SRC_IR1, SRC_NONE, FN_PASS, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b0); nxt = S_MRD; end
      S_IMA:  begin uw = mk(SRC_IR2, SRC_NONE, FN_PASS, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b0); nxt = S_MRD; end
      S_MRD:  begin uw = mk(SRC_NONE, SRC_NONE, FN_IDLE, rd_ld, 1'b1, 1'b0, 1'b0); nxt = S_MACC; end
      S_MACC: uw = mk(SRC_R0, SRC_MBRR, FN_ADD, ld_bit(LD_R0), 1'b0, 1'b0, 1'b0);
      S_IDX:  begin uw = mk(SRC_R1, SRC_IR2, FN_ADD, ld_bit(LD_IR2), 1'b0, 1'b0, 1'b0); nxt = S_IMA; end
      S_LIT:  uw = mk(SRC_R0, SRC_IR1, FN_ADD, ld_bit(LD_R0), 1'b0, 1'b0, 1'b0);
      S_SA:   begin uw = mk(SRC_R0, SRC_IR2, FN_ADD, ld_bit(LD_MAR), 1'b0, 1'b0, 1'b0); nxt = S_SD; end
      S_SD:   begin uw = mk(SRC_IR1, SRC_NONE, FN_PASS, ld_bit(LD_MBRW), 1'b0, 1'b0, 1'b0); nxt = S_SWR; end
      S_SWR:  uw = mk(SRC_NONE, SRC_NONE, FN_IDLE, '0, 1'b0, 1'b1, 1'b0);
      S_BEQ:  uw = mk(SRC_PC, SRC_IR1, FN_ADD, z_flag ? ld_bit(LD_PC) : '0, 1'b0, 1'b0, 1'b0);
      S_CS:   begin uw = mk(SRC_PC, SRC_NONE, FN_PASS, ld_bit(LD_RET), 1'b0, 1'b0, 1'b0); nxt = S_CJ; end
      S_CJ:   uw = mk(SRC_PC, SRC_IR1, FN_ADD, ld_bit(LD_PC), 1'b0, 1'b0, 1'b0);
      S_RET:  uw = mk(SRC_RET, SRC_NONE, FN_PASS, ld_bit(LD_PC), 1'b0, 1'b0, 1'b0);
      default: ;
    endcase
  end
endmodule

// File: rtl/ms_advance.sv
module ms_advance import ms_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  input  logic   dispatch,
  input  ustep_t first,
  input  ustep_t nxt,
  output ustep_t st
);
  always_ff @(posedge clk) begin
    if (rst)           st <= S_FA0;
    else if (hold)     st <= st;
    else if (dispatch) st <= first;
    else               st <= nxt;
  end

  AST_STALL_HOLDS_STEP: assert property (@(posedge clk) disable iff (rst)
    hold |=> (st == $past(st))); // R3
endmodule

// File: rtl/triword_useq.sv
module triword_useq import ms_pkg::*; #(
  parameter int IR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IR_W-1:0] ir0,
  input  logic            z_flag,
  input  logic            mem_ready,
  output logic [2:0]      src_a,
  output logic [2:0]      src_b,
  output logic [1:0]      alu_fn,
  output logic [8:0]      ld_en,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            pc_inc,
  output logic            pc_clr
);
  ustep_t st, first, nxt;
  uword_t uw;
  logic   dispatch;
  logic   hold;

  ms_decode #(.IR_W(IR_W)) u_dec (.ir0(ir0), .first(first));

  ms_ustore u_rom (
    .st(st), .z_flag(z_flag), .mem_ready(mem_ready),
    .uw(uw), .nxt(nxt), .dispatch(dispatch)
  );

  assign hold = (uw.rd | uw.wr) & ~mem_ready;

  ms_advance u_adv (
    .clk(clk), .rst(rst), .hold(hold), .dispatch(dispatch),
    .first(first), .nxt(nxt), .st(st)
  );

  assign src_a  = rst ? SRC_NONE : uw.sa;
  assign src_b  = rst ? SRC_NONE : uw.sb;
  assign alu_fn = rst ? FN_IDLE  : uw.fn;
  assign ld_en  = rst ? '0       : uw.ld;
  assign mem_rd = ~rst & uw.rd;
  assign mem_wr = ~rst & uw.wr;
  assign pc_inc = ~rst & uw.inc;
  assign pc_clr = rst;

  AST_RESET_ENTERS_FETCH: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> pc_inc); // R1
  AST_ADDR_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> mem_rd); // R2
  AST_NO_LOAD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |-> (ld_en == '0)); // R3
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R3
  AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !$past(mem_wr)) |-> $past(ld_en[LD_MBRW])); // R8
endmodule

// File: tb/triword_useq_test.sv
`timescale 1ns/1ps
module triword_useq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] ir0 = '0;
  logic z_flag = 1'b0;
  logic mem_ready = 1'b1;
  logic [2:0] src_a, src_b;
  logic [1:0] alu_fn;
  logic [8:0] ld_en;
  logic mem_rd, mem_wr, pc_inc, pc_clr;

  int vec = 0;
  int miss = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  triword_useq uut (
    .clk(clk), .rst(rst), .ir0(ir0), .z_flag(z_flag), .mem_ready(mem_ready),
    .src_a(src_a), .src_b(src_b), .alu_fn(alu_fn), .ld_en(ld_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_inc(pc_inc), .pc_clr(pc_clr)
  );

  localparam logic [2:0] NO = 3'd0, R0 = 3'd1, R1 = 3'd2, I1 = 3'd3, I2 = 3'd4,
                         PC = 3'd5, RT = 3'd6, MB = 3'd7;
  localparam logic [1:0] IDL = 2'd0, PAS = 2'd1, ADD = 2'd2;
  localparam logic [8:0] M_MAR = 9'h001, M_MBRR = 9'h002, M_MBRW = 9'h004,
                         M_IR0 = 9'h008, M_R0 = 9'h040, M_IR2 = 9'h020,
                         M_PC = 9'h080, M_RET = 9'h100;

  localparam int K_NOP = 0, K_RADD = 1, K_MADD = 2, K_IADD = 3, K_LADD = 4,
                 K_STOR = 5, K_BEQ = 6, K_CALL = 7, K_RET = 8;

  // {ir0, z, kind}
  localparam int NVEC = 16;
  localparam logic [20:0] VEC [NVEC] = '{
    {16'h0000, 1'b0, 4'd1},  // R4 register add
    {16'hE383, 1'b1, 4'd1},  // R12 junk fields, still register add
    {16'h0004, 1'b0, 4'd2},  // R5
    {16'h0008, 1'b0, 4'd3},  // R6
    {16'h000C, 1'b1, 4'd4},  // R7
    {16'h0400, 1'b0, 4'd5},  // R8
    {16'hA41C, 1'b1, 4'd5},  // R8 any parameter
    {16'h1400, 1'b1, 4'd6},  // R9 taken
    {16'h1400, 1'b0, 4'd6},  // R9 not taken
    {16'h1404, 1'b0, 4'd7},  // R10
    {16'h1408, 1'b1, 4'd8},  // R11
    {16'h140C, 1'b0, 4'd0},  // R12 flow class, unused parameter
    {16'h0800, 1'b0, 4'd0},  // R12 class 2
    {16'h1C00, 1'b1, 4'd0},  // R12 class 7
    {16'h0024, 1'b0, 4'd0},  // R12 arith class, parameter 9
    {16'h0000, 1'b1, 4'd1}   // R4 again after no-ops
  };

  function automatic logic [20:0] cw(input logic [2:0] a, input logic [2:0] b,
                                     input logic [1:0] f, input logic [8:0] l,
                                     input logic r, input logic w,
                                     input logic i, input logic c);
    return {a, b, f, l, r, w, i, c};
  endfunction

  function automatic logic [20:0] f_addr();
    return cw(PC, NO, PAS, M_MAR, 1'b0, 1'b0, 1'b1, 1'b0);
  endfunction
  function automatic logic [20:0] f_read(input logic rdy);
    return cw(NO, NO, IDL, rdy ? M_MBRR : 9'h000, 1'b1, 1'b0, 1'b0, 1'b0);
  endfunction
  function automatic logic [20:0] f_load(input int w);
    return cw(MB, NO, PAS, M_IR0 << w, 1'b0, 1'b0, 1'b0, 1'b0);
  endfunction

  function automatic int n_exec(input int k);
    case (k)
      K_RADD, K_LADD, K_BEQ, K_RET: return 1;
      K_CALL:         return 2;
      K_MADD, K_STOR: return 3;
      K_IADD:         return 4;
      default:        return 0;
    endcase
  endfunction

  function automatic logic [20:0] exp_exec(input int k, input logic z, input int i);
    logic [20:0] rd_w, acc_w;
    rd_w  = f_read(1'b1);
    acc_w = cw(R0, MB, ADD, M_R0, 1'b0, 1'b0, 1'b0, 1'b0);
    case (k)
      K_RADD: return cw(R0, R1, ADD, M_R0, 1'b0, 1'b0, 1'b0, 1'b0);
      K_LADD: return cw(R0, I1, ADD, M_R0, 1'b0, 1'b0, 1'b0, 1'b0);
      K_MADD: return (i == 0) ? cw(I1, NO, PAS, M_MAR, 1'b0, 1'b0, 1'b0, 1'b0) :
                     (i == 1) ? rd_w : acc_w;
      K_IADD: return (i == 0) ? cw(R1, I2, ADD, M_IR2, 1'b0, 1'b0, 1'b0, 1'b0) :
                     (i == 1) ? cw(I2, NO, PAS, M_MAR, 1'b0, 1'b0, 1'b0, 1'b0) :
                     (i == 2) ? rd_w : acc_w;
      K_STOR: return (i == 0) ? cw(R0, I2, ADD, M_MAR, 1'b0, 1'b0, 1'b0, 1'b0) :
                     (i == 1) ? cw(I1, NO, PAS, M_MBRW, 1'b0, 1'b0, 1'b0, 1'b0) :
                                cw(NO, NO, IDL, 9'h000, 1'b0, 1'b1, 1'b0, 1'b0);
      K_BEQ:  return cw(PC, I1, ADD, z ? M_PC : 9'h000, 1'b0, 1'b0, 1'b0, 1'b0);
      K_CALL: return (i == 0) ? cw(PC, NO, PAS, M_RET, 1'b0, 1'b0, 1'b0, 1'b0) :
                                cw(PC, I1, ADD, M_PC, 1'b0, 1'b0, 1'b0, 1'b0);
      K_RET:  return cw(RT, NO, PAS, M_PC, 1'b0, 1'b0, 1'b0, 1'b0);
      default: return '0;
    endcase
  endfunction

  // called at a negedge with inputs already set; consumes one cycle
  task automatic chk(input logic [20:0] exp, input string tag);
    logic [20:0] act;
    #1;
    act = {src_a, src_b, alu_fn, ld_en, mem_rd, mem_wr, pc_inc, pc_clr};
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [15:0] ir, input logic z, input int k,
                           input int stall_f, input int stall_x);
    ir0 = ir; z_flag = z; mem_ready = 1'b1;
    for (int w = 0; w < 3; w++) begin
      chk(f_addr(), "R2 fetch address");
      if (w == 1) begin
        for (int s = 0; s < stall_f; s++) begin
          mem_ready = 1'b0;
          chk(f_read(1'b0), "R3 fetch read stalled");
        end
        mem_ready = 1'b1;
      end
      chk(f_read(1'b1), "R2 fetch read");
      chk(f_load(w), "R2 fetch load");
    end
    for (int i = 0; i < n_exec(k); i++) begin
      logic [20:0] e;
      e = exp_exec(k, z, i);
      if (e[3] || e[2]) begin
        for (int s = 0; s < stall_x; s++) begin
          mem_ready = 1'b0;
          chk({e[20:13], 9'h000, e[3:0]}, "R3 execute memory stalled");
        end
        mem_ready = 1'b1;
      end
      case (k)
        K_RADD: chk(e, "R4 register add");
        K_MADD: chk(e, "R5 memory add");
        K_IADD: chk(e, "R6 indexed add");
        K_LADD: chk(e, "R7 literal add");
        K_STOR: chk(e, "R8 indexed store");
        K_BEQ:  chk(e, "R9 branch if zero");
        K_CALL: chk(e, "R10 call");
        default: chk(e, "R11 return");
      endcase
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      miss++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cw(NO, NO, IDL, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1), "R1 reset word");
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_instr(VEC[v][20:5], VEC[v][4], int'(VEC[v][3:0]), 0, 0);

    // R3: stalls in fetch read, operand read and store write
    run_instr(16'h0004, 1'b0, K_MADD, 3, 2);
    run_instr(16'h0008, 1'b1, K_IADD, 1, 4);
    run_instr(16'h0400, 1'b0, K_STOR, 2, 3);

    // R1: reset in the middle of a call
    ir0 = 16'h1404; z_flag = 1'b0; mem_ready = 1'b1;
    for (int w = 0; w < 3; w++) begin
      chk(f_addr(), "R2 fetch address");
      chk(f_read(1'b1), "R2 fetch read");
      chk(f_load(w), "R2 fetch load");
    end
    chk(exp_exec(K_CALL, 1'b0, 0), "R10 call save");
    rst = 1'b1;
    chk(cw(NO, NO, IDL, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1), "R1 reset mid-call");
    rst = 1'b0;
    run_instr(16'h000C, 1'b0, K_LADD, 0, 0);
    run_instr(16'h1408, 1'b0, K_RET, 0, 0);
    // R12: after the last step, fetch restarts
    chk(f_addr(), "R12 back to fetch");

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule